// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Set-Less-Than

This block is a purely combinational integer ALU. It is built as a chain of identical one-bit slices. Each slice holds a full adder, an AND gate, an OR gate, a selectable inverter on its second operand and a four-way result picker. The carry leaves each slice and enters the one above it, so the slices form a ripple chain from the least significant bit up to the most significant bit. One set of control inputs covers several jobs: addition, subtraction, bitwise AND and OR, signed set-less-than, and an equality test that reads the zero flag after a subtraction.

A user drives the two operands, an invert-second-operand control, the carry into bit 0 and a two-bit operation select. Subtraction and set-less-than both need the inverter on and a carry-in of 1, so a host can tie these two controls to one wire. For set-less-than, the sum bit of the top slice, corrected by the overflow flag, is fed back to the picker of bit 0. All upper result bits are forced to zero in that mode.

Top module: `alu_bitslice`

## Requirements
- R1: With invertB=0, carryIn=0 and opSel=2'b00, result equals (opA + opB) modulo 2^WIDTH.
- R2: With invertB=1, carryIn=1 and opSel=2'b00, result equals (opA - opB) modulo 2^WIDTH.
- R3: With opSel=2'b10, result equals opA AND the effective second operand, where the effective second operand is ~opB when invertB=1 and opB when invertB=0.
- R4: With opSel=2'b01, result equals opA OR the effective second operand, where the effective second operand is the same as in R3.
- R5: With invertB=1, carryIn=1 and opSel=2'b11, result bit 0 is 1 exactly when opA is less than opB as signed two's-complement numbers. All other result bits are 0. This holds even when opA - opB overflows.
- R6: zero is 1 exactly when every bit of result is 0. After a subtraction, this means opA equals opB.
- R7: carryOut equals the carry out of the top bit of opA + effective second operand + carryIn, for every opSel.
- R8: overflow is 1 exactly when that same sum overflows as a signed value. This happens when the two addends have the same sign and the sum's sign differs from it. It holds for every opSel.
- R9: The block holds no state. Every output follows the current inputs within the same clock cycle, and an earlier operation has no effect on a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| invertB | input | 1 | 1 inverts every bit of opB before the slices use it |
| carryIn | input | 1 | Carry into slice 0 |
| opSel | input | 2 | 00 sum, 01 OR, 10 AND, 11 less-than line |
| result | output | 32 | Selected result |
| zero | output | 1 | 1 when result is all zeros |
| carryOut | output | 1 | Carry out of the top slice |
| overflow | output | 1 | Signed overflow of the adder chain |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The driver applies a new operation just after a rising edge. It queues the expected result, flags and carry, which it computes from plain arithmetic and signed comparison. The monitor pops and compares that item at the following falling edge, half a period later, when the ripple chain has settled. The input sequence runs back to back, switching operation on every cycle, so any leftover effect of the previous operation would show as a mismatch.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  localparam int ALU_WIDTH = 32;

  // One-hot choice of the value a slice hands to its result output.
  typedef struct packed {
    logic pickLess;
    logic pickAnd;
    logic pickOr;
    logic pickSum;
  } aluPick_t;

  // Strobes sent from control to datapath.
  typedef struct packed {
    logic     invB;
    logic     cin;
    aluPick_t pick;
  } aluStrobes_t;
endpackage

// File: rtl/alu_ctrl.sv
`timescale 1ns/1ps
module alu_ctrl
  import alu_pkg::*;
(
  input  logic        invertB,
  input  logic        carryIn,
  input  logic [1:0]  opSel,
  output aluStrobes_t strobes
);
  always_comb begin
    strobes.invB          = invertB;
    strobes.cin           = carryIn;
    strobes.pick.pickSum  = (opSel == 2'b00);
    strobes.pick.pickOr   = (opSel == 2'b01);
    strobes.pick.pickAnd  = (opSel == 2'b10);
    strobes.pick.pickLess = (opSel == 2'b11);
  end
endmodule

// File: rtl/alu_slice.sv
`timescale 1ns/1ps
module alu_slice
  import alu_pkg::*;
(
  input  logic     aBit,
  input  logic     bBit,
  input  logic     invB,
  input  logic     cin,
  input  logic     lessIn,
  input  aluPick_t pick,
  output logic     resBit,
  output logic     sumBit,
  output logic     cout
);
  logic bEff;

  always_comb begin
    bEff   = bBit ^ invB;
    sumBit = aBit ^ bEff ^ cin;
    cout   = (aBit & bEff) | (aBit & cin) | (bEff & cin);
    resBit = (pick.pickSum  & sumBit)
           | (pick.pickOr   & (aBit | bEff))
           | (pick.pickAnd  & (aBit & bEff))
           | (pick.pickLess & lessIn);
  end
endmodule

// File: rtl/alu_datapath.sv
`timescale 1ns/1ps
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = ALU_WIDTH
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             carryOut,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carryChain;
  logic [WIDTH-1:0] sumVec;
  logic             setFeed;

  assign carryChain[0] = strobes.cin;

  // The top sum bit, fixed up by overflow, feeds the less line of bit 0.
  assign overflow = carryChain[MSB] ^ carryChain[WIDTH];
  assign setFeed  = sumVec[MSB] ^ overflow;
  assign carryOut = carryChain[WIDTH];
  assign zero     = ~|result;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == 0) begin : g_lsb
      alu_slice u_slice (
        .aBit(opA[i]), .bBit(opB[i]), .invB(strobes.invB),
        .cin(carryChain[i]), .lessIn(setFeed), .pick(strobes.pick),
        .resBit(result[i]), .sumBit(sumVec[i]), .cout(carryChain[i+1])
      );
    end else begin : g_upper
      alu_slice u_slice (
        .aBit(opA[i]), .bBit(opB[i]), .invB(strobes.invB),
        .cin(carryChain[i]), .lessIn(1'b0), .pick(strobes.pick),
        .resBit(result[i]), .sumBit(sumVec[i]), .cout(carryChain[i+1])
      );
    end
  end

  // Behavioural cross-checks of the ripple chain.
  logic [WIDTH-1:0] chkB;
  logic [WIDTH:0]   chkSum;
  always_comb begin
    chkB   = strobes.invB ? ~opB : opB;
    chkSum = {1'b0, opA} + {1'b0, chkB} + {{WIDTH{1'b0}}, strobes.cin};
    if (strobes.pick.pickSum && !strobes.invB && !strobes.cin)
      p_add_sum_r1: assert (result == opA + opB) else $error("R1 add mismatch");
    if (strobes.pick.pickSum && strobes.invB && strobes.cin)
      p_sub_diff_r2: assert (result == opA - opB) else $error("R2 sub mismatch");
    if (strobes.pick.pickAnd)
      p_and_bits_r3: assert (result == (opA & chkB)) else $error("R3 and mismatch");
    if (strobes.pick.pickOr)
      p_or_bits_r4: assert (result == (opA | chkB)) else $error("R4 or mismatch");
    if (strobes.pick.pickLess && strobes.invB && strobes.cin)
      p_slt_value_r5: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opA) < $signed(opB))})
        else $error("R5 slt mismatch");
    p_carry_out_r7: assert ({carryOut, sumVec} == chkSum) else $error("R7 carry mismatch");
    p_no_overflow_r8: assert (overflow ==
        ((opA[MSB] == chkB[MSB]) && (chkSum[MSB] != opA[MSB]))) else $error("R8 overflow mismatch");
  end
endmodule

// File: rtl/alu_bitslice.sv
`timescale 1ns/1ps
module alu_bitslice
  import alu_pkg::*;
(
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        invertB,
  input  logic        carryIn,
  input  logic [1:0]  opSel,
  output logic [31:0] result,
  output logic        zero,
  output logic        carryOut,
  output logic        overflow
);
  aluStrobes_t strobes;

  alu_ctrl u_ctrl (
    .invertB(invertB), .carryIn(carryIn), .opSel(opSel), .strobes(strobes)
  );

  alu_datapath #(.WIDTH(32)) u_dp (
    .opA(opA), .opB(opB), .strobes(strobes),
    .result(result), .zero(zero), .carryOut(carryOut), .overflow(overflow)
  );
endmodule

// File: tb/alu_bitslice_bench.sv
`timescale 1ns/1ps
module alu_bitslice_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        invertB = 1'b0, carryIn = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] result;
  logic        zero, carryOut, overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        z, co, ov;
    string       tag;
  } expItem_t;
  expItem_t scoreQ[$];

  always #4 clk = ~clk;  // 125 MHz

  alu_bitslice u_alu_bitslice (
    .opA(opA), .opB(opB), .invertB(invertB), .carryIn(carryIn), .opSel(opSel),
    .result(result), .zero(zero), .carryOut(carryOut), .overflow(overflow)
  );

  function automatic expItem_t model(input logic [31:0] a, input logic [31:0] b,
                                     input logic inv, input logic ci,
                                     input logic [1:0] sel, input string tag);
    expItem_t e;
    logic [31:0] be;
    logic [32:0] s;
    be = inv ? ~b : b;
    s  = {1'b0, a} + {1'b0, be} + {32'd0, ci};
    e.co = s[32];
    e.ov = (a[31] == be[31]) && (s[31] != a[31]);
    case (sel)
      2'b00: e.res = s[31:0];
      2'b01: e.res = a | be;
      2'b10: e.res = a & be;
      default: e.res = {31'd0, (inv && ci) ? ($signed(a) < $signed(b)) : (s[31] ^ e.ov)};
    endcase
    e.z   = (e.res == 32'd0);
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic inv,
                       input logic ci, input logic [1:0] sel, input string tag);
    @(posedge clk);
    #1;
    opA = a; opB = b; invertB = inv; carryIn = ci; opSel = sel;
    scoreQ.push_back(model(a, b, inv, ci, sel, tag));
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (a=%h b=%h inv=%b ci=%b sel=%b)",
               tag, what, act, exp, opA, opB, invertB, carryIn, opSel);
    end
  endtask

  // Monitor: results are due half a period after each drive.
  initial begin
    forever begin
      @(negedge clk);
      if (scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        cmp(e.tag, "result", result, e.res);
        cmp("R6", "zero", {31'd0, zero}, {31'd0, e.z});
        cmp("R7", "carryOut", {31'd0, carryOut}, {31'd0, e.co});
        cmp("R8", "overflow", {31'd0, overflow}, {31'd0, e.ov});
      end
    end
  end

  logic [31:0] corner [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000,
                              32'h7FFF_FFFF, 32'h0000_0001, 32'h5555_AAAA};

  initial begin
    // Idle state with all inputs low: result 0, zero 1, no carry, no overflow.
    @(negedge clk);
    cmp("R9", "idle result", result, 32'd0);
    cmp("R6", "idle zero", {31'd0, zero}, 32'd1);
    cmp("R7", "idle carry", {31'd0, carryOut}, 32'd0);
    cmp("R8", "idle overflow", {31'd0, overflow}, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        drive(corner[i], corner[j], 1'b0, 1'b0, 2'b00, "R1");
        drive(corner[i], corner[j], 1'b1, 1'b1, 2'b00, "R2");
        drive(corner[i], corner[j], 1'b0, 1'b0, 2'b10, "R3");
        drive(corner[i], corner[j], 1'b1, 1'b0, 2'b10, "R3");
        drive(corner[i], corner[j], 1'b0, 1'b0, 2'b01, "R4");
        drive(corner[i], corner[j], 1'b1, 1'b0, 2'b01, "R4");
        drive(corner[i], corner[j], 1'b1, 1'b1, 2'b11, "R5");
      end
    end
    // Equality through subtraction, and SLT at overflow extremes.
    drive(32'h1234_5678, 32'h1234_5678, 1'b1, 1'b1, 2'b00, "R6");
    drive(32'h1234_5678, 32'h1234_5679, 1'b1, 1'b1, 2'b00, "R6");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b1, 2'b11, "R5");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 1'b1, 2'b11, "R5");
    for (int k = 0; k < 300; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (k % 4 == 0) rb = ra;
      drive(ra, rb, 1'b0, 1'b0, 2'b00, "R1");
      drive(ra, rb, 1'b1, 1'b1, 2'b00, "R2");
      drive(ra, rb, k[0], 1'b0, 2'b10, "R3");
      drive(ra, rb, k[1], 1'b0, 2'b01, "R4");
      drive(ra, rb, 1'b1, 1'b1, 2'b11, "R5");
      drive(ra, rb, k[2], k[3], 2'(k), "R9");
    end
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule